// File: doc/BRIEF.md
# Multi-Mode Word Shift Unit

This block moves an operand word by exactly one bit position, to the left or to the right. Three shift modes are available: logical, arithmetic and circular. Whatever the mode, the bit that drops off the end of the word is reported on a carry flag. A fourth mode code passes the operand through untouched and keeps the held carry flag as it is.

The shifted word and its carry appear combinationally on one pair of outputs. A second pair holds a registered copy. That copy loads on a clock enable and clears on a synchronous reset. A datapath can take the result in the same cycle, or keep it as a flag-bearing result for later steps.

Top module: `wordshift_unit`

## Requirements
- R1: Logical mode (mode 00) with dir 0 (left) gives `{op[6:0],0}`, and the carry is op[7].
- R2: Arithmetic mode (mode 01) with dir 0 gives the same word and carry as R1. This is the two's-complement value times two: 0x27 gives 0x4E, and 0xE3 gives 0xC6.
- R3: Logical mode with dir 1 (right) gives `{0,op[7:1]}`, and the carry is op[0]. For example, 0xD7 gives 0x6B.
- R4: Arithmetic mode with dir 1 gives `{op[7],op[7:1]}`, and the carry is op[0]. For example, 0xD7 gives 0xEB.
- R5: Circular mode (mode 10) with dir 0 gives `{op[6:0],op[7]}`, and the carry is op[7]. For example, 0xD7 gives 0xAF.
- R6: Circular mode with dir 1 gives `{op[0],op[7:1]}`, and the carry is op[0]. For example, 0xD7 gives 0xEB.
- R7: Mode 11 puts the operand on the word output unchanged, in either direction. The carry output shows the registered carry flag, and that flag keeps its value.
- R8: When en is high at a rising clock edge, res_q and cy_q take the combinational word and carry of that cycle.
- R9: When en is low at a rising clock edge, res_q and cy_q keep their values.
- R10: When rst is high at a rising clock edge, res_q and cy_q become 0. This takes priority over en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Load enable for the registered result |
| operand | input | 8 | Word to shift |
| dir | input | 1 | 0 shifts left, 1 shifts right |
| mode | input | 2 | 00 logical, 01 arithmetic, 10 circular, 11 pass |
| res_comb | output | 8 | Combinational shifted word |
| cy_comb | output | 1 | Combinational carry (bit shifted out) |
| res_q | output | 8 | Registered shifted word |
| cy_q | output | 1 | Registered carry flag |

## Verification
Every one of the 256 operand values is applied in each of the four mode codes and both directions. This sweep separates the modes by the bit they insert:
- A zero fill shows up on operands whose vacated end would otherwise receive a 1.
- A sign copy differs from a zero fill only for operands with the top bit set.
- A rotate differs from a zero fill only when the outgoing bit is 1.

Operands whose two end bits differ also expose a swapped carry source. Enable is dropped on a regular fraction of the cycles, so the hold behaviour is seen on the registered pair. The held flag carried across pass-mode cycles shows whether mode 11 keeps the carry. A reset in the middle of the run, asserted with enable high, shows that reset takes priority.

// File: rtl/wordshift_pkg.sv
package wordshift_pkg;
    typedef enum logic [1:0] {
        SH_LOGIC = 2'b00,
        SH_ARITH = 2'b01,
        SH_CIRC  = 2'b10,
        SH_PASS  = 2'b11
    } shmode_e;

    typedef struct packed {
        logic [7:0] word;
        logic       carry;
    } shres_s;
endpackage

// File: rtl/shift_left_core.sv
module shift_left_core #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op,
    input  logic             circ,
    output logic [WIDTH-1:0] word,
    output logic             out_bit
);
    localparam int MSB = WIDTH - 1;
    logic fill;

    // Circular mode feeds the top bit back in; the others insert zero.
    assign fill    = circ ? op[MSB] : 1'b0;
    assign word    = {op[MSB-1:0], fill};
    assign out_bit = op[MSB];
endmodule

// File: rtl/shift_right_core.sv
module shift_right_core #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op,
    input  logic             arith,
    input  logic             circ,
    output logic [WIDTH-1:0] word,
    output logic             out_bit
);
    localparam int MSB = WIDTH - 1;
    logic fill;

    always_comb begin
        if (arith)     fill = op[MSB];
        else if (circ) fill = op[0];
        else           fill = 1'b0;
    end

    assign word    = {fill, op[MSB:1]};
    assign out_bit = op[0];
endmodule

// File: rtl/shift_select.sv
module shift_select #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op,
    input  logic             dir,
    input  logic             pass,
    input  logic             held_carry,
    input  logic [WIDTH-1:0] left_word,
    input  logic             left_bit,
    input  logic [WIDTH-1:0] right_word,
    input  logic             right_bit,
    output logic [WIDTH-1:0] word,
    output logic             carry
);
    always_comb begin
        if (pass) begin
            word  = op;
            carry = held_carry;
        end else if (dir) begin
            word  = right_word;
            carry = right_bit;
        end else begin
            word  = left_word;
            carry = left_bit;
        end
    end
endmodule

// File: rtl/wordshift_unit.sv
module wordshift_unit
    import wordshift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] operand,
    input  logic             dir,
    input  logic [1:0]       mode,
    output logic [WIDTH-1:0] res_comb,
    output logic             cy_comb,
    output logic [WIDTH-1:0] res_q,
    output logic             cy_q
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             carry;
    } state_s;

    state_s st_d, st_q;
    shmode_e mode_e;
    logic [WIDTH-1:0] lw, rw, sel_word;
    logic lb, rb, sel_carry;

    assign mode_e = shmode_e'(mode);

    shift_left_core #(.WIDTH(WIDTH)) u_left (
        .op(operand), .circ(mode_e == SH_CIRC), .word(lw), .out_bit(lb)
    );

    shift_right_core #(.WIDTH(WIDTH)) u_right (
        .op(operand), .arith(mode_e == SH_ARITH), .circ(mode_e == SH_CIRC),
        .word(rw), .out_bit(rb)
    );

    shift_select #(.WIDTH(WIDTH)) u_sel (
        .op(operand), .dir(dir), .pass(mode_e == SH_PASS),
        .held_carry(st_q.carry),
        .left_word(lw), .left_bit(lb), .right_word(rw), .right_bit(rb),
        .word(sel_word), .carry(sel_carry)
    );

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.word  = sel_word;
            st_d.carry = sel_carry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_comb = sel_word;
    assign cy_comb  = sel_carry;
    assign res_q    = st_q.word;
    assign cy_q     = st_q.carry;
endmodule

// File: rtl/wordshift_checker.sv
module wordshift_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [WIDTH-1:0] operand,
    input logic             dir,
    input logic [1:0]       mode,
    input logic [WIDTH-1:0] res_comb,
    input logic             cy_comb,
    input logic [WIDTH-1:0] res_q,
    input logic             cy_q
);
    localparam int MSB = WIDTH - 1;

    // R1 and R2: a left shift in logical or arithmetic mode doubles the word
    assert_left_double_R1: assert property (@(posedge clk) disable iff (rst)
        (en && !dir && !mode[1]) |=> (res_q == {$past(operand[MSB-1:0]), 1'b0})
                                     && (cy_q == $past(operand[MSB])));

    assert_lsr_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (en && dir && mode == 2'b00) |=> (!res_q[MSB] && cy_q == $past(operand[0])));

    assert_asr_sign_R4: assert property (@(posedge clk) disable iff (rst)
        (en && dir && mode == 2'b01) |=> (res_q[MSB] == $past(operand[MSB])));

    assert_rol_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (en && !dir && mode == 2'b10) |=> (res_q[0] == $past(operand[MSB])));

    assert_pass_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (en && mode == 2'b11) |=> (res_q == $past(operand)) && $stable(cy_q));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(res_q) && $stable(cy_q)));

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (res_q == '0 && !cy_q));

    always_comb begin
        if (mode == 2'b11) begin
            assert_pass_word_R7: assert (res_comb == operand && cy_comb == cy_q);
        end
    end
endmodule

bind wordshift_unit wordshift_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .en(en), .operand(operand), .dir(dir), .mode(mode),
    .res_comb(res_comb), .cy_comb(cy_comb), .res_q(res_q), .cy_q(cy_q)
);

// File: tb/sim_wordshift_unit.sv
`timescale 1ns/1ps
module sim_wordshift_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [7:0] operand = 8'h00;
    logic       dir = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] res_comb, res_q;
    logic       cy_comb, cy_q;

    int checks = 0;
    int fails = 0;
    int m_word = 0;
    int m_cy = 0;

    always #2.5 clk = ~clk;

    wordshift_unit u0 (
        .clk(clk), .rst(rst), .en(en), .operand(operand), .dir(dir), .mode(mode),
        .res_comb(res_comb), .cy_comb(cy_comb), .res_q(res_q), .cy_q(cy_q)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0h expected=%0h (op=%0h dir=%0d mode=%0d)",
                     req, got, exp, operand, dir, mode);
        end
    endtask

    function automatic string tag_of(input int md, input int d);
        if (md == 3) return "R7";
        if (md == 0) return d ? "R3" : "R1";
        if (md == 1) return d ? "R4" : "R2";
        return d ? "R6" : "R5";
    endfunction

    // Behavioural model: word and carry as integers, computed arithmetically.
    task automatic model(input int op, input int md, input int d, input int held,
                         output int w, output int c);
        if (md == 3) begin
            w = op; c = held;
        end else if (d == 0) begin
            w = (op * 2) % 256 + ((md == 2) ? op / 128 : 0);
            c = op / 128;
        end else begin
            w = op / 2;
            if (md == 1 && op >= 128) w = w + 128;
            if (md == 2) w = w + (op % 2) * 128;
            c = op % 2;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // One vector: drive at negedge, check combinational, clock, check registered.
    task automatic apply(input int op, input int md, input int d, input bit e, input bit r);
        int w, c;
        string t;
        @(negedge clk);
        operand = op[7:0]; mode = md[1:0]; dir = d[0]; en = e; rst = r;
        t = tag_of(md, d);
        model(op, md, d, m_cy, w, c);
        #1;
        check(t, res_comb, w);
        check(t, cy_comb, c);
        @(posedge clk);
        if (r) begin
            m_word = 0; m_cy = 0;
        end else if (e) begin
            m_word = w; m_cy = c;
        end
        @(negedge clk);
        check(r ? "R10" : (e ? "R8" : "R9"), res_q, m_word);
        check(r ? "R10" : (e ? "R8" : "R9"), cy_q, m_cy);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // Reset state (R10)
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10", res_q, 0);
        check("R10", cy_q, 0);
        rst = 1'b0;

        // Directed examples: R2 doubling, R3/R4/R5/R6 on 0xD7
        apply(8'h27, 1, 0, 1'b1, 1'b0); check("R2", res_q, 8'h4E);
        apply(8'hE3, 1, 0, 1'b1, 1'b0); check("R2", res_q, 8'hC6);
        apply(8'hD7, 0, 1, 1'b1, 1'b0); check("R3", res_q, 8'h6B);
        apply(8'hD7, 1, 1, 1'b1, 1'b0); check("R4", res_q, 8'hEB);
        apply(8'hD7, 2, 0, 1'b1, 1'b0); check("R5", res_q, 8'hAF);
        apply(8'hD7, 2, 1, 1'b1, 1'b0); check("R6", res_q, 8'hEB);
        // Repeated logical right shifts of 0x75 (R3)
        apply(8'h75, 0, 1, 1'b1, 1'b0); check("R3", res_q, 8'h3A);
        apply(8'h3A, 0, 1, 1'b1, 1'b0); check("R3", res_q, 8'h1D);
        apply(8'h1D, 0, 1, 1'b1, 1'b0); check("R3", res_q, 8'h0E);

        // Full sweep of every mode, direction and operand, enable sometimes low
        for (int md = 0; md < 4; md++) begin
            for (int d = 0; d < 2; d++) begin
                for (int op = 0; op < 256; op++) begin
                    apply(op, md, d, (op % 5) != 3, 1'b0);
                end
            end
        end

        // Reset wins over enable (R10)
        apply(8'hFF, 0, 0, 1'b1, 1'b0);
        apply(8'hFF, 0, 0, 1'b1, 1'b1);
        check("R10", res_q, 0);
        // Pass mode keeps the cleared flag, then a set flag (R7)
        apply(8'h5A, 3, 1, 1'b1, 1'b0);
        check("R7", cy_q, 0);
        apply(8'h81, 0, 1, 1'b1, 1'b0);
        apply(8'h00, 3, 0, 1'b1, 1'b0);
        check("R7", cy_q, 1);

        summary();
        $finish;
    end
endmodule